// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits after a three-channel pixel sampler and fans a single stream of digitized pixels out onto two output ports per colour channel. One pixel arrives on every clock. In single-port mode every pixel goes to port A at the full pixel rate. In the two dual-port modes, successive pixels alternate between port A and port B. In the parallel variant a pixel pair appears on both ports at once, every second clock. In the interleaved variant each incoming pixel updates one port in turn.

A horizontal sync input, with selectable polarity, marks the start of each line. Its leading edge restarts the A/B alternation, so the first pixel of every line lands on port A even when the previous line had an odd length. The block also drives an active-high sync output, a data-clock enable that marks when the ports carry new data, and output-enable signals for the two ports' tri-state drivers. Data, sync and data clock all pass through the same two register stages, so they stay aligned whatever the mode.

Top module: `pdm_top`

## Requirements
- R1: With dual_en low, each pixel appears on port_a two rising edges after it is sampled, port_b reads all zeros and oe_b is low. Channel c of a pixel occupies bits [8c+7:8c] of pix_in and of each port (channel 0 red, 1 green, 2 blue).
- R2: With dual_en high, the pixels of a line are numbered from 0 at the line start. Even-numbered pixels go to port A and odd-numbered pixels go to port B.
- R3: A line starts with the pixel sampled on the clock at which the normalized sync level goes from 0 to 1. A sync edge after an odd number of pixels still restarts the alternation at port A.
- R4: With dual_en and par_en high, port_a and port_b both load on the same edge, two edges after an odd-numbered pixel is sampled. Port_a then shows the preceding even-numbered pixel and port_b the odd one. Sampling an even-numbered pixel leaves both ports unchanged.
- R5: With dual_en high and par_en low, an even-numbered pixel updates only port_a and an odd-numbered pixel updates only port_b, each two edges after sampling.
- R6: dck_ce is 1 on every cycle in single-port mode. In dual-port modes it is 1 exactly in the cycles whose ports present an odd-numbered pixel, giving half the pixel rate.
- R7: hs_out is the normalized sync level delayed by two edges, the same delay as the data.
- R8: oe_a equals the inverse of pdown, and oe_b is high only when dual_en is high and pdown is low, both two edges after sampling.
- R9: With hs_pol high the sync input is active high. With hs_pol low it is inverted before edge detection and before hs_out.
- R10: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 24 | One pixel, three 8-bit channels |
| hsync_in | input | 1 | Horizontal sync, polarity set by hs_pol |
| hs_pol | input | 1 | 1: sync active high, 0: active low |
| dual_en | input | 1 | 1 selects two-port output |
| par_en | input | 1 | In dual mode, 1 selects pair output, 0 interleaved |
| pdown | input | 1 | Power-down, disables both port drivers |
| port_a | output | 24 | Port A data, three channels |
| port_b | output | 24 | Port B data, three channels |
| dck_ce | output | 1 | Data clock enable marking new output data |
| hs_out | output | 1 | Active-high aligned sync output |
| oe_a | output | 1 | Port A driver enable |
| oe_b | output | 1 | Port B driver enable |

## Verification
Every result, including data, dck_ce, hs_out and both enables, is due two rising edges after the inputs that cause it are sampled. Mode and power-down inputs are sampled alongside the pixel and take the same path. The driver computes each expected output snapshot as it applies an input and queues it. The monitor samples on the falling edge and pops an entry only once three have been queued. This places every comparison exactly two edges after the matching input, and the parallel-mode ports, which only move on odd pixels, are checked against values held since the last pair.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    typedef enum logic [1:0] {
        PM_SINGLE     = 2'd0,
        PM_INTERLEAVE = 2'd1,
        PM_PARALLEL   = 2'd2
    } port_mode_e;

    function automatic port_mode_e decode_mode(input logic dual, input logic par);
        if (!dual)
            return PM_SINGLE;
        else if (par)
            return PM_PARALLEL;
        else
            return PM_INTERLEAVE;
    endfunction

endpackage

// File: rtl/pdm_line_phase.sv
module pdm_line_phase
    import pdm_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix_in,
    input  logic          hsync_in,
    input  logic          hs_pol,
    input  logic          dual_en,
    input  logic          par_en,
    input  logic          pdown,
    output logic [PW-1:0] s1_pix,
    output logic          s1_odd,
    output logic          s1_hs,
    output port_mode_e    s1_mode,
    output logic          s1_pdown
);

    typedef struct packed {
        logic [PW-1:0] pix;
        logic          odd;
        logic          hs;
        port_mode_e    mode;
        logic          pdown;
    } stage_t;

    stage_t st_d, st_q;
    logic   hs_now;
    logic   line_start;

    always_comb begin
        hs_now     = hs_pol ? hsync_in : ~hsync_in;
        line_start = hs_now & ~st_q.hs;
        st_d       = st_q;
        st_d.pix   = pix_in;
        st_d.hs    = hs_now;
        st_d.odd   = line_start ? 1'b0 : ~st_q.odd;
        st_d.mode  = decode_mode(dual_en, par_en);
        st_d.pdown = pdown;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.odd   <= 1'b1;
            st_q.mode  <= PM_SINGLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_pix   = st_q.pix;
    assign s1_odd   = st_q.odd;
    assign s1_hs    = st_q.hs;
    assign s1_mode  = st_q.mode;
    assign s1_pdown = st_q.pdown;

    // R3: a sync leading edge makes the next registered pixel position 0
    assert_line_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (s1_odd == 1'b0));

    // R2: away from line starts the position alternates
    assert_pos_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> (s1_odd != $past(s1_odd)));

endmodule

// File: rtl/pdm_port_router.sv
module pdm_port_router
    import pdm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*CW-1:0] s1_pix,
    input  logic              s1_odd,
    input  logic              s1_hs,
    input  port_mode_e        s1_mode,
    input  logic              s1_pdown,
    output logic [NCH*CW-1:0] port_a,
    output logic [NCH*CW-1:0] port_b,
    output logic              dck_ce,
    output logic              hs_out,
    output logic              oe_a,
    output logic              oe_b
);

    localparam int PW = NCH * CW;

    typedef struct packed {
        logic [PW-1:0] hold;
        logic [PW-1:0] a;
        logic [PW-1:0] b;
        logic          ce;
        logic          hs;
        logic          oe_a;
        logic          oe_b;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.hs   = s1_hs;
        o_d.oe_a = ~s1_pdown;
        o_d.oe_b = (s1_mode != PM_SINGLE) & ~s1_pdown;
        o_d.ce   = (s1_mode == PM_SINGLE) ? 1'b1 : s1_odd;
        for (int c = 0; c < NCH; c++) begin
            unique case (s1_mode)
                PM_SINGLE: begin
                    o_d.a[c*CW +: CW] = s1_pix[c*CW +: CW];
                    o_d.b[c*CW +: CW] = '0;
                end
                PM_INTERLEAVE: begin
                    if (s1_odd)
                        o_d.b[c*CW +: CW] = s1_pix[c*CW +: CW];
                    else
                        o_d.a[c*CW +: CW] = s1_pix[c*CW +: CW];
                end
                PM_PARALLEL: begin
                    if (s1_odd) begin
                        o_d.a[c*CW +: CW] = o_q.hold[c*CW +: CW];
                        o_d.b[c*CW +: CW] = s1_pix[c*CW +: CW];
                    end else begin
                        o_d.hold[c*CW +: CW] = s1_pix[c*CW +: CW];
                    end
                end
                default: begin
                    o_d.a[c*CW +: CW] = o_q.a[c*CW +: CW];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            o_q <= '0;
        else
            o_q <= o_d;
    end

    assign port_a = o_q.a;
    assign port_b = o_q.b;
    assign dck_ce = o_q.ce;
    assign hs_out = o_q.hs;
    assign oe_a   = o_q.oe_a;
    assign oe_b   = o_q.oe_b;

    // R8: port B is never enabled while port A is off
    assert_oeb_needs_oea_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.oe_b |-> o_q.oe_a);

    // R6: in a sustained dual mode the data clock enable never stays high
    assert_ce_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.ce && s1_mode != PM_SINGLE && $past(s1_mode) != PM_SINGLE) |=> !o_q.ce);

    // R4: an even-position pixel in parallel mode leaves both ports still
    assert_pair_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_mode == PM_PARALLEL && !s1_odd) |=> ($stable(port_a) && $stable(port_b)));

    // R5: interleaved mode touches only one port per pixel
    assert_interleave_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_mode == PM_INTERLEAVE) |=> ($stable(port_a) || $stable(port_b)));

endmodule

// File: rtl/pdm_top.sv
module pdm_top
    import pdm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*CW-1:0] pix_in,
    input  logic              hsync_in,
    input  logic              hs_pol,
    input  logic              dual_en,
    input  logic              par_en,
    input  logic              pdown,
    output logic [NCH*CW-1:0] port_a,
    output logic [NCH*CW-1:0] port_b,
    output logic              dck_ce,
    output logic              hs_out,
    output logic              oe_a,
    output logic              oe_b
);

    localparam int PW = NCH * CW;

    logic [PW-1:0] s1_pix;
    logic          s1_odd;
    logic          s1_hs;
    port_mode_e    s1_mode;
    logic          s1_pdown;

    pdm_line_phase #(.PW(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_in   (pix_in),
        .hsync_in (hsync_in),
        .hs_pol   (hs_pol),
        .dual_en  (dual_en),
        .par_en   (par_en),
        .pdown    (pdown),
        .s1_pix   (s1_pix),
        .s1_odd   (s1_odd),
        .s1_hs    (s1_hs),
        .s1_mode  (s1_mode),
        .s1_pdown (s1_pdown)
    );

    pdm_port_router #(.NCH(NCH), .CW(CW)) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_pix   (s1_pix),
        .s1_odd   (s1_odd),
        .s1_hs    (s1_hs),
        .s1_mode  (s1_mode),
        .s1_pdown (s1_pdown),
        .port_a   (port_a),
        .port_b   (port_b),
        .dck_ce   (dck_ce),
        .hs_out   (hs_out),
        .oe_a     (oe_a),
        .oe_b     (oe_b)
    );

endmodule

// File: tb/tb_pdm_top.sv
module tb_pdm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix_in = '0;
    logic        hsync_in = 1'b0;
    logic        hs_pol = 1'b1;
    logic        dual_en = 1'b0;
    logic        par_en = 1'b0;
    logic        pdown = 1'b0;
    logic [23:0] port_a, port_b;
    logic        dck_ce, hs_out, oe_a, oe_b;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pdm_top dut (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .hsync_in(hsync_in),
        .hs_pol(hs_pol), .dual_en(dual_en), .par_en(par_en), .pdown(pdown),
        .port_a(port_a), .port_b(port_b), .dck_ce(dck_ce), .hs_out(hs_out),
        .oe_a(oe_a), .oe_b(oe_b)
    );

    typedef struct packed {
        logic [23:0] a;
        logic [23:0] b;
        logic        ce;
        logic        hs;
        logic        oea;
        logic        oeb;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    // mode settings applied by the driver
    logic  m_dual = 0, m_par = 0, m_pd = 0, m_pol = 1;
    string m_tag = "R1";

    // reference state built from the requirements
    logic        r_prev = 0;
    logic        r_odd = 1;
    logic [23:0] r_a = '0, r_b = '0, r_hold = '0;

    task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [23:0] px, input logic hs_level);
        exp_t e;
        logic hs_now, ls, pos;
        @(posedge clk);
        #1;
        pix_in   = px;
        hsync_in = m_pol ? hs_level : ~hs_level;
        hs_pol   = m_pol;
        dual_en  = m_dual;
        par_en   = m_par;
        pdown    = m_pd;
        hs_now = hs_level;
        ls     = hs_now & ~r_prev;
        r_prev = hs_now;
        pos    = ls ? 1'b0 : ~r_odd;
        r_odd  = pos;
        e.hs  = hs_now;
        e.oea = ~m_pd;
        e.oeb = m_dual & ~m_pd;
        if (!m_dual) begin
            r_a = px; r_b = '0; e.ce = 1'b1;
        end else begin
            e.ce = pos;
            if (m_par) begin
                if (pos) begin r_a = r_hold; r_b = px; end
                else r_hold = px;
            end else begin
                if (pos) r_b = px; else r_a = px;
            end
        end
        e.a = r_a;
        e.b = r_b;
        expq.push_back(e);
        tagq.push_back(m_tag);
    endtask

    // line of n pixels preceded by a sync pulse of w cycles (pixels also valid during sync)
    task automatic line(input int n, input int w, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = seed + 8'(i);
            step({v ^ 8'h5A, v ^ 8'hA5, v}, (i < w));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && expq.size() >= 3) begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, "port_a", port_a, e.a);
            check(t, "port_b", port_b, e.b);
            check("R6", "dck_ce", {23'd0, dck_ce}, {23'd0, e.ce});
            check("R7", "hs_out", {23'd0, hs_out}, {23'd0, e.hs});
            check("R8", "oe_a/oe_b", {22'd0, oe_a, oe_b}, {22'd0, e.oea, e.oeb});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check("R10", "port_a", port_a, '0);
        check("R10", "port_b", port_b, '0);
        check("R10", "flags", {20'd0, dck_ce, hs_out, oe_a, oe_b}, '0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: single-port mode
        m_tag = "R1";
        line(10, 2, 8'h10);
        // R2 R5: interleaved, odd line length then restart (R3)
        m_dual = 1; m_par = 0; m_tag = "R2/R5";
        line(9, 2, 8'h30);
        m_tag = "R3/R5";
        line(7, 1, 8'h50);
        line(8, 3, 8'h70);
        // R4: parallel pairs, odd line lengths (R3)
        m_par = 1; m_tag = "R4";
        line(10, 2, 8'h90);
        m_tag = "R3/R4";
        line(7, 2, 8'hB0);
        line(9, 1, 8'hC8);
        // R9: inverted sync polarity in interleaved mode
        m_par = 0; m_pol = 0; m_tag = "R9";
        line(8, 2, 8'hD0);
        line(5, 2, 8'hE0);
        // R8: power-down in dual then single mode
        m_pd = 1; m_tag = "R8";
        line(6, 1, 8'h20);
        m_dual = 0;
        line(4, 1, 8'h40);
        m_pd = 0; m_pol = 1; m_tag = "R1";
        line(6, 2, 8'h60);
        line(4, 0, 8'h00);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule